// File: doc/BRIEF.md
# External Bus Read Wait-State and Float Sequencer

This block sequences read cycles on an external memory bus. A cycle begins when a request is seen while the sequencer is idle. It then drives an address-latch pulse and holds the active-low read strobe for a base state plus a number of wait states. After the strobe it signals completion and, when needed, keeps the bus idle for an extra turnaround period before another cycle may begin. The wait-state count and the turnaround length come from three active-low configuration bits, a region select and a configuration-fetch flag. All of these are captured when the request is accepted.

With the extended-float bit high, the two wait-select bits pick 0 to 3 wait states and the turnaround is normal. With the extended-float bit low, the turnaround is extended and only 1 or 3 wait states are available. The configuration-fetch cycle after reset always uses 3 wait states and the extended turnaround. An optional ready input, gated by its own enable, can stretch the strobe. A separate enable runs a square-wave wait clock at half the clock rate.

The states are IDLE, ADDR, STRB, WAIT, HOLD, END and FLOAT. The transitions are:
- IDLE to ADDR on an accepted request.
- ADDR to STRB always.
- STRB to WAIT when wait states are programmed.
- STRB or the last WAIT state to HOLD when the stretch input is enabled and sampled low.
- STRB, the last WAIT state or HOLD to END otherwise.
- END to FLOAT when the extended turnaround is latched, and END to IDLE otherwise.
- FLOAT to IDLE after its counted cycles.

Top module: `xbus_wait_ctl`

## Requirements
- R1: After reset, ale and cyc_done are 0, rd_n is 1, and wclk is 0.
- R2: A request sampled in IDLE makes ale high for exactly one cycle, in the next cycle. rd_n is high while ale is high.
- R3: With cyc_region=1, cfg_fetch=0 and cfg_xfloat_n=1, rd_n is low for 1+W cycles. W is 0, 1, 2 or 3 for cfg_wsel_n equal to 11, 10, 01 or 00.
- R4: With cyc_region=1, cfg_fetch=0 and cfg_xfloat_n=0, W is 1 for cfg_wsel_n 11 or 10, and W is 3 for 01 or 00.
- R5: With cyc_region=0 and cfg_fetch=0, W is 0 and the turnaround is normal, whatever the configuration bits hold.
- R6: Take the cyc_done cycle as T, with a request held from then on. The next ale comes at T+2 after a normal turnaround and at T+4 after an extended one. Extended turnaround applies when R4 or R7 applies.
- R7: With cfg_fetch=1, W is 3 and the turnaround is extended, whatever the region and configuration bits.
- R8: Suppose wait_en=1 and wait_n is sampled low at the end of the last programmed strobe cycle. Then rd_n stays low one more cycle for each consecutive clock edge that samples wait_n low.
- R9: With wait_en=0, wait_n has no effect on the strobe length.
- R10: cyc_done is a one-cycle pulse in the first cycle that rd_n is high after the strobe.
- R11: With wclk_en=1, wclk toggles every clock. With wclk_en=0, wclk is 0 from the next clock on.
- R12: Requests that arrive while a cycle is in progress produce no further ale in that cycle.
- R13: Configuration, region and fetch inputs are captured when the request is accepted. Later changes do not affect that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_req | input | 1 | Read cycle request, accepted in IDLE |
| cyc_region | input | 1 | 1 selects the configured slow region |
| cfg_fetch | input | 1 | Marks the configuration-fetch cycle after reset |
| cfg_xfloat_n | input | 1 | Active-low extended-float enable |
| cfg_wsel_n | input | 2 | Active-low wait-select code |
| wait_en | input | 1 | Enables the wait_n stretch input |
| wait_n | input | 1 | Active-low ready stretch input |
| wclk_en | input | 1 | Enables the wait clock output |
| wclk | output | 1 | Square-wave wait clock |
| ale | output | 1 | Address latch enable, one cycle per bus cycle |
| rd_n | output | 1 | Active-low read strobe |
| cyc_done | output | 1 | One-cycle end-of-strobe pulse |

## Verification
All outputs are decoded from registered state, so ale comes one edge after the request edge, and rd_n falls one edge after that. cyc_done comes one edge after the last low-strobe edge. The next ale follows cyc_done by two edges, or by four with extended turnaround. The bench drives inputs and samples outputs on falling edges. It counts ale-high and rd_n-low falling edges until cyc_done, then counts falling edges from cyc_done to the next ale. For the stretch test, wait_n is released on a known falling edge, and the expected strobe length is derived from the edges that sampled it low.

// File: rtl/xbus_wait_pkg.sv
package xbus_wait_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_STRB  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_HOLD  = 3'd4,
        ST_END   = 3'd5,
        ST_FLOAT = 3'd6
    } bus_state_e;

    typedef struct packed {
        logic [1:0] wait_cnt;
        logic       ext_float;
    } timing_cfg_t;

endpackage

// File: rtl/xbus_wait_decode.sv
module xbus_wait_decode
    import xbus_wait_pkg::*;
#(
    parameter int FETCH_WAIT = 3,
    parameter int EXT_SHORT  = 1,
    parameter int EXT_LONG   = 3
) (
    input  logic       region_hit,
    input  logic       fetch,
    input  logic       xfloat_n,
    input  logic [1:0] wsel_n,
    output timing_cfg_t timing
);

    always_comb begin
        timing = '0;
        if (fetch) begin
            // configuration fetch: slowest timing, no matter the bits
            timing.wait_cnt  = 2'(FETCH_WAIT);
            timing.ext_float = 1'b1;
        end else if (!region_hit) begin
            timing.wait_cnt  = 2'd0;
            timing.ext_float = 1'b0;
        end else if (xfloat_n) begin
            // compatible timing: count is the inverted select code
            timing.wait_cnt  = ~wsel_n;
            timing.ext_float = 1'b0;
        end else begin
            // extended float: only the upper select bit matters
            timing.wait_cnt  = wsel_n[1] ? 2'(EXT_SHORT) : 2'(EXT_LONG);
            timing.ext_float = 1'b1;
        end
    end

endmodule

// File: rtl/xbus_wclk_gen.sv
module xbus_wclk_gen #(
    parameter int WCLK_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wclk
);

    localparam int HW = (WCLK_HALF > 1) ? $clog2(WCLK_HALF) : 1;

    logic [HW-1:0] half_cnt_q;
    logic          wclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt_q <= '0;
            wclk_q     <= 1'b0;
        end else if (!en) begin
            half_cnt_q <= '0;
            wclk_q     <= 1'b0;
        end else if (half_cnt_q == HW'(WCLK_HALF - 1)) begin
            half_cnt_q <= '0;
            wclk_q     <= ~wclk_q;
        end else begin
            half_cnt_q <= half_cnt_q + HW'(1);
        end
    end

    assign wclk = wclk_q;

endmodule

// File: rtl/xbus_wait_fsm.sv
module xbus_wait_fsm
    import xbus_wait_pkg::*;
#(
    parameter int FLOAT_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  timing_cfg_t timing,
    input  logic        wait_en,
    input  logic        wait_n,
    output logic        ale,
    output logic        rd_n,
    output logic        done
);

    localparam int FW = (FLOAT_CYC > 1) ? $clog2(FLOAT_CYC) : 1;

    bus_state_e    state_q, state_d;
    logic [1:0]    wcnt_q, wcnt_d;
    logic          ext_q, ext_d;
    logic [FW-1:0] fcnt_q, fcnt_d;
    logic          stretch;

    assign stretch = wait_en & ~wait_n;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        ext_d   = ext_q;
        fcnt_d  = fcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_ADDR;
                    wcnt_d  = timing.wait_cnt;
                    ext_d   = timing.ext_float;
                end
            end
            ST_ADDR: state_d = ST_STRB;
            ST_STRB: begin
                if (wcnt_q != 2'd0) begin
                    state_d = ST_WAIT;
                    wcnt_d  = wcnt_q - 2'd1;
                end else if (stretch) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_END;
                end
            end
            ST_WAIT: begin
                if (wcnt_q != 2'd0) begin
                    wcnt_d = wcnt_q - 2'd1;
                end else if (stretch) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_END;
                end
            end
            ST_HOLD: begin
                if (!stretch) state_d = ST_END;
            end
            ST_END: begin
                if (ext_q) begin
                    state_d = ST_FLOAT;
                    fcnt_d  = FW'(FLOAT_CYC - 1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_FLOAT: begin
                if (fcnt_q == '0) state_d = ST_IDLE;
                else              fcnt_d  = fcnt_q - FW'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            ext_q   <= 1'b0;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            ext_q   <= ext_d;
            fcnt_q  <= fcnt_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        ale  = 1'b0;
        rd_n = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_ADDR:                   ale  = 1'b1;
            ST_STRB, ST_WAIT, ST_HOLD: rd_n = 1'b0;
            ST_END:                    done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/xbus_wait_ctl.sv
module xbus_wait_ctl
    import xbus_wait_pkg::*;
#(
    parameter int FLOAT_CYC  = 2,
    parameter int WCLK_HALF  = 1,
    parameter int FETCH_WAIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_req,
    input  logic       cyc_region,
    input  logic       cfg_fetch,
    input  logic       cfg_xfloat_n,
    input  logic [1:0] cfg_wsel_n,
    input  logic       wait_en,
    input  logic       wait_n,
    input  logic       wclk_en,
    output logic       wclk,
    output logic       ale,
    output logic       rd_n,
    output logic       cyc_done
);

    timing_cfg_t timing;

    xbus_wait_decode #(
        .FETCH_WAIT(FETCH_WAIT),
        .EXT_SHORT (1),
        .EXT_LONG  (3)
    ) u_decode (
        .region_hit(cyc_region),
        .fetch     (cfg_fetch),
        .xfloat_n  (cfg_xfloat_n),
        .wsel_n    (cfg_wsel_n),
        .timing    (timing)
    );

    xbus_wait_fsm #(
        .FLOAT_CYC(FLOAT_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (cyc_req),
        .timing (timing),
        .wait_en(wait_en),
        .wait_n (wait_n),
        .ale    (ale),
        .rd_n   (rd_n),
        .done   (cyc_done)
    );

    xbus_wclk_gen #(
        .WCLK_HALF(WCLK_HALF)
    ) u_wclk (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wclk_en),
        .wclk (wclk)
    );

endmodule

// File: rtl/xbus_wait_chk.sv
module xbus_wait_chk #(
    parameter int WCLK_HALF = 1
) (
    input logic clk,
    input logic rst_n,
    input logic wait_en,
    input logic wait_n,
    input logic wclk_en,
    input logic wclk,
    input logic ale,
    input logic rd_n,
    input logic cyc_done
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);  // R2

    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> rd_n);  // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);  // R10

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (rd_n && !$past(rd_n)));  // R10

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !ale);  // R6

    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> !($past(wait_en) && !$past(wait_n)));  // R8

    AST_WCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wclk_en) |-> !wclk);  // R11

    generate
        if (WCLK_HALF == 1) begin : g_fast
            AST_WCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wclk_en) |-> (wclk != $past(wclk)));  // R11
        end
    endgenerate

endmodule

bind xbus_wait_ctl xbus_wait_chk #(.WCLK_HALF(WCLK_HALF)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wait_en (wait_en),
    .wait_n  (wait_n),
    .wclk_en (wclk_en),
    .wclk    (wclk),
    .ale     (ale),
    .rd_n    (rd_n),
    .cyc_done(cyc_done)
);

// File: tb/xbus_wait_ctl_test.sv
module xbus_wait_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_req = 1'b0;
    logic       cyc_region = 1'b0;
    logic       cfg_fetch = 1'b0;
    logic       cfg_xfloat_n = 1'b1;
    logic [1:0] cfg_wsel_n = 2'b11;
    logic       wait_en = 1'b0;
    logic       wait_n = 1'b1;
    logic       wclk_en = 1'b0;
    logic       wclk, ale, rd_n, cyc_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #5 clk = ~clk;

    xbus_wait_ctl uut (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_region(cyc_region),
        .cfg_fetch(cfg_fetch), .cfg_xfloat_n(cfg_xfloat_n), .cfg_wsel_n(cfg_wsel_n),
        .wait_en(wait_en), .wait_n(wait_n), .wclk_en(wclk_en), .wclk(wclk),
        .ale(ale), .rd_n(rd_n), .cyc_done(cyc_done)
    );

    // {region, fetch, xfloat_n, wsel_n[1:0], strobe cycles[3:0], gap[3:0]}
    localparam logic [12:0] VECS [0:11] = '{
        {1'b1, 1'b0, 1'b1, 2'b11, 4'd1, 4'd2},
        {1'b1, 1'b0, 1'b1, 2'b10, 4'd2, 4'd2},
        {1'b1, 1'b0, 1'b1, 2'b01, 4'd3, 4'd2},
        {1'b1, 1'b0, 1'b1, 2'b00, 4'd4, 4'd2},
        {1'b1, 1'b0, 1'b0, 2'b11, 4'd2, 4'd4},
        {1'b1, 1'b0, 1'b0, 2'b10, 4'd2, 4'd4},
        {1'b1, 1'b0, 1'b0, 2'b01, 4'd4, 4'd4},
        {1'b1, 1'b0, 1'b0, 2'b00, 4'd4, 4'd4},
        {1'b0, 1'b0, 1'b0, 2'b00, 4'd1, 4'd2},
        {1'b0, 1'b0, 1'b1, 2'b00, 4'd1, 4'd2},
        {1'b1, 1'b1, 1'b1, 2'b11, 4'd4, 4'd4},
        {1'b0, 1'b1, 1'b1, 2'b11, 4'd4, 4'd4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // starts a cycle; at return we are on the cyc_done falling edge
    task automatic run_cycle(output int ales, output int lows);
        @(negedge clk);
        cyc_req = 1'b1;
        @(negedge clk);
        cyc_req = 1'b0;
        ales = 0;
        lows = 0;
        for (int g = 0; g < 40; g++) begin
            if (ale) ales++;
            if (!rd_n) lows++;
            if (ale && !rd_n) check(1'b0, "R2", 0, 1);
            if (cyc_done) break;
            @(negedge clk);
        end
    endtask

    task automatic drain();
        cyc_req = 1'b0;
        for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (cyc_done) break;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int ales, lows, gap;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ale == 1'b0, "R1", ale, 0);
        check(rd_n == 1'b1, "R1", rd_n, 1);
        check(cyc_done == 1'b0, "R1", cyc_done, 0);
        check(wclk == 1'b0, "R1", wclk, 0);

        // table walk: R3, R4, R5, R7 strobe length and R6 turnaround
        for (int i = 0; i < 12; i++) begin
            cyc_region   = VECS[i][12];
            cfg_fetch    = VECS[i][11];
            cfg_xfloat_n = VECS[i][10];
            cfg_wsel_n   = VECS[i][9:8];
            if (VECS[i][11])       tag = "R7";
            else if (!VECS[i][12]) tag = "R5";
            else if (VECS[i][10])  tag = "R3";
            else                   tag = "R4";
            run_cycle(ales, lows);
            check(ales == 1, "R2", ales, 1);
            check(lows == int'(VECS[i][7:4]), tag, lows, int'(VECS[i][7:4]));
            cyc_req = 1'b1;
            gap = 0;
            for (int g = 0; g < 20; g++) begin
                @(negedge clk);
                gap++;
                if (gap == 1) check(cyc_done == 1'b0, "R10", cyc_done, 0);
                if (ale) break;
            end
            check(gap == int'(VECS[i][3:0]), "R6", gap, int'(VECS[i][3:0]));
            drain();
        end

        // R8: stretch with wait_n low for three edges, zero programmed waits
        cyc_region = 1'b1; cfg_fetch = 1'b0; cfg_xfloat_n = 1'b1; cfg_wsel_n = 2'b11;
        wait_en = 1'b1; wait_n = 1'b0;
        fork
            begin
                do @(negedge clk); while (rd_n);
                repeat (3) @(negedge clk);
                wait_n = 1'b1;
            end
        join_none
        run_cycle(ales, lows);
        check(lows == 4, "R8", lows, 4);
        drain();

        // R9: disabled stretch input ignored
        wait_en = 1'b0; wait_n = 1'b0;
        run_cycle(ales, lows);
        check(lows == 1, "R9", lows, 1);
        drain();
        wait_n = 1'b1;

        // R12: request held through the whole cycle
        cfg_wsel_n = 2'b00;
        @(negedge clk);
        cyc_req = 1'b1;
        ales = 0;
        for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (ale) ales++;
            if (cyc_done) break;
        end
        check(ales == 1, "R12", ales, 1);
        drain();

        // R13: configuration changed after acceptance
        cfg_xfloat_n = 1'b0; cfg_wsel_n = 2'b00;
        @(negedge clk);
        cyc_req = 1'b1;
        @(negedge clk);
        cyc_req = 1'b0;
        cfg_xfloat_n = 1'b1; cfg_wsel_n = 2'b11; cyc_region = 1'b0;
        lows = 0;
        for (int g = 0; g < 40; g++) begin
            if (!rd_n) lows++;
            if (cyc_done) break;
            @(negedge clk);
        end
        check(lows == 4, "R13", lows, 4);
        cyc_req = 1'b1;
        gap = 0;
        for (int g = 0; g < 20; g++) begin
            @(negedge clk);
            gap++;
            if (ale) break;
        end
        check(gap == 4, "R13", gap, 4);
        drain();

        // R11: wait clock
        wclk_en = 1'b1;
        @(negedge clk);
        begin
            logic a, b, c;
            a = wclk;
            @(negedge clk); b = wclk;
            @(negedge clk); c = wclk;
            check(b != a, "R11", b, !a);
            check(c != b, "R11", c, !b);
        end
        wclk_en = 1'b0;
        @(negedge clk);
        check(wclk == 1'b0, "R11", wclk, 0);
        @(negedge clk);
        check(wclk == 1'b0, "R11", wclk, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule